// File: doc/BRIEF.md
# Self-Calibrating Baud-Rate UART Command Slave

This block is the serial front end of a slave device that has no fixed baud rate. After reset it does not know how fast the master talks, so it hunts for a working bit period. The master sends a stream of calibration bytes (0xAA). The slave first sweeps from its fastest setting towards slower ones until one calibration byte arrives intact. That setting is the upper rate limit. It then sweeps from its slowest setting towards faster ones until another calibration byte arrives intact. That setting is the lower limit. The slave places its working bit period midway between the two limits and announces lock by sending two 0x55 bytes at that period.

Once locked, the block is a command port. Every byte received with a valid stop bit is echoed back on the serial output unchanged. The same byte is offered to the local logic on a valid/ready stream. Commands carry one byte per transfer. `cmd_data` stays stable while `cmd_valid` is high and `cmd_ready` is low. A transfer completes on a clock edge where both `cmd_valid` and `cmd_ready` are high. The command path has a single holding slot. A byte that arrives while that slot is still unaccepted is dropped from the stream but is still echoed. Only a reset discards the calibrated rate.

The rate is held as a bit-period divisor of the system clock. The fastest setting uses divisor CLK_HZ/BAUD_MAX and the slowest uses CLK_HZ/BAUD_MIN. The serial line idles high, frames are one low start bit, eight data bits with the least significant bit first, and one high stop bit, with no parity.

Top module: `autobaud_uart_slave`

## Requirements
- R1: After reset `serial_out` is high, `cmd_valid` is low, and the bit-period divisor is the fastest setting (CLK_HZ/BAUD_MAX).
- R2: During the downward sweep, each received byte that is not 0xAA, or that has a low stop bit, increases the divisor by exactly one before the next byte.
- R3: The first intact 0xAA in the downward sweep stores the current divisor as the upper limit and sets the divisor to the slowest setting (CLK_HZ/BAUD_MIN).
- R4: During the upward sweep, each mismatching byte decreases the divisor by exactly one, and the first intact 0xAA stores the current divisor as the lower limit.
- R5: After the lower limit is found, the divisor becomes (upper + lower + 1) / 2 rounded down, which is the average rounded half up. Two 0x55 frames are then sent at that divisor, so each bit lasts exactly that many clock cycles.
- R6: A mismatch at the slowest divisor in the downward sweep wraps the divisor to the fastest setting. A mismatch at the fastest divisor in the upward sweep wraps it to the slowest setting.
- R7: After lock, every byte received with a high stop bit is retransmitted on `serial_out` unchanged at the locked divisor.
- R8: After lock, a received 0xAA is handled like any other command byte: it is echoed and presented on `cmd_data`, and the divisor is not changed.
- R9: `cmd_valid` stays high and `cmd_data` stays stable until `cmd_ready` is high. A byte received while a byte is pending is not presented on the stream but is still echoed.
- R10: Before lock, no byte is presented on `cmd_valid`, and `serial_out` stays high until the 0x55 pair.
- R11: After lock, a byte with a low stop bit is neither echoed nor presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the calibrated rate |
| serial_in | input | 1 | Serial data from the master, idle high, asynchronous |
| serial_out | output | 1 | Serial data to the master (lock pattern and echoes), idle high |
| cmd_valid | output | 1 | A received command byte is waiting |
| cmd_ready | input | 1 | Local logic accepts the waiting byte |
| cmd_data | output | 8 | The waiting command byte |

## Verification
The bench builds the block with a 125 MHz clock and baud limits chosen so that the fastest divisor is 8 and the slowest is 20. Each sweep therefore spans only thirteen settings. At this scale a full wrap of both sweeps costs a few dozen bytes. The bench sends each calibration and junk byte at exactly the divisor the slave should hold at that moment, so the stored limits, and therefore the centred divisor, are known exactly. It checks that divisor by measuring the width of the low bits in the 0x55 frames.

// File: rtl/abr_pkg.sv
package abr_pkg;

  localparam logic [7:0] CAL_BYTE = 8'hAA;
  localparam logic [7:0] ACK_BYTE = 8'h55;

  typedef enum logic [2:0] {
    R_IDLE,
    R_START,
    R_DATA,
    R_STOP,
    R_HOLD
  } rx_st_t;

  typedef enum logic [2:0] {
    C_DOWN,
    C_UP,
    C_ACK1,
    C_ACK2,
    C_RUN
  } ctl_st_t;

endpackage

// File: rtl/abr_sync.sv
module abr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = q[STAGES-1];

endmodule

// File: rtl/abr_rx.sv
module abr_rx
  import abr_pkg::*;
#(
  parameter int DW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line,
  input  logic [DW-1:0] div,
  output logic          done,
  output logic          ok,
  output logic [7:0]    data
);

  rx_st_t        st;
  logic [DW-1:0] cnt;
  logic [DW-1:0] dl;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= R_IDLE;
      cnt  <= '0;
      dl   <= '0;
      bitn <= '0;
      sh   <= '0;
      done <= 1'b0;
      ok   <= 1'b0;
      data <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        R_IDLE: begin
          if (!line) begin
            dl  <= div;
            cnt <= (div >> 1) - DW'(1);
            st  <= R_START;
          end
        end
        R_START: begin
          if (cnt != '0) begin
            cnt <= cnt - DW'(1);
          end else if (!line) begin
            cnt  <= dl - DW'(1);
            bitn <= '0;
            st   <= R_DATA;
          end else begin
            st <= R_IDLE;
          end
        end
        R_DATA: begin
          if (cnt != '0) begin
            cnt <= cnt - DW'(1);
          end else begin
            sh  <= {line, sh[7:1]};
            cnt <= dl - DW'(1);
            if (bitn == 3'd7) st <= R_STOP;
            else              bitn <= bitn + 3'd1;
          end
        end
        R_STOP: begin
          if (cnt != '0) begin
            cnt <= cnt - DW'(1);
          end else begin
            done <= 1'b1;
            ok   <= line;
            data <= sh;
            st   <= line ? R_IDLE : R_HOLD;
          end
        end
        R_HOLD: begin
          if (line) st <= R_IDLE;
        end
        default: st <= R_IDLE;
      endcase
    end
  end

  // R2: one frame yields one result pulse, so one sweep step
  a_r2_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/abr_tx.sv
module abr_tx #(
  parameter int DW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [7:0]    din,
  input  logic [DW-1:0] div,
  output logic          line,
  output logic          busy
);

  logic [8:0]    sh;
  logic [DW-1:0] cnt;
  logic [DW-1:0] dl;
  logic [3:0]    nb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      cnt  <= '0;
      dl   <= '0;
      nb   <= '0;
      line <= 1'b1;
      busy <= 1'b0;
    end else if (!busy) begin
      if (go) begin
        sh   <= {1'b1, din};
        line <= 1'b0;
        cnt  <= div - DW'(1);
        dl   <= div;
        nb   <= '0;
        busy <= 1'b1;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - DW'(1);
    end else if (nb == 4'd9) begin
      busy <= 1'b0;
      line <= 1'b1;
    end else begin
      line <= sh[0];
      sh   <= {1'b1, sh[8:1]};
      nb   <= nb + 4'd1;
      cnt  <= dl - DW'(1);
    end
  end

  // R5: the line rests high between frames
  a_r5_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line);

endmodule

// File: rtl/abr_ctrl.sv
module abr_ctrl
  import abr_pkg::*;
#(
  parameter int DW       = 11,
  parameter int DIV_FAST = 192,
  parameter int DIV_SLOW = 1724
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_done,
  input  logic          rx_ok,
  input  logic [7:0]    rx_data,
  input  logic          tx_busy,
  output logic          tx_go,
  output logic [7:0]    tx_byte,
  output logic [DW-1:0] div,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [7:0]    cmd_data
);

  localparam logic [DW-1:0] D_FAST = DW'(DIV_FAST);
  localparam logic [DW-1:0] D_SLOW = DW'(DIV_SLOW);

  ctl_st_t       st;
  logic [DW-1:0] up_lim;
  logic [DW:0]   csum;
  logic          match;
  logic          pend;
  logic [7:0]    echo;

  assign match = rx_ok && (rx_data == CAL_BYTE);
  assign csum  = {1'b0, up_lim} + {1'b0, div} + (DW+1)'(1);

  always_comb begin
    tx_go   = 1'b0;
    tx_byte = ACK_BYTE;
    case (st)
      C_ACK1, C_ACK2: tx_go = !tx_busy;
      C_RUN: begin
        tx_go   = pend && !tx_busy;
        tx_byte = echo;
      end
      default: tx_go = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= C_DOWN;
      div    <= D_FAST;
      up_lim <= D_FAST;
    end else begin
      case (st)
        C_DOWN: if (rx_done) begin
          if (match) begin
            up_lim <= div;
            div    <= D_SLOW;
            st     <= C_UP;
          end else begin
            div <= (div == D_SLOW) ? D_FAST : div + DW'(1);
          end
        end
        C_UP: if (rx_done) begin
          if (match) begin
            div <= csum[DW:1];
            st  <= C_ACK1;
          end else begin
            div <= (div == D_FAST) ? D_SLOW : div - DW'(1);
          end
        end
        C_ACK1: if (!tx_busy) st <= C_ACK2;
        C_ACK2: if (!tx_busy) st <= C_RUN;
        default: st <= C_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      echo      <= '0;
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
    end else begin
      if (st == C_RUN && rx_done && rx_ok) begin
        pend <= 1'b1;
        echo <= rx_data;
      end else if (tx_go && st == C_RUN) begin
        pend <= 1'b0;
      end
      if (st == C_RUN && rx_done && rx_ok && (!cmd_valid || cmd_ready)) begin
        cmd_valid <= 1'b1;
        cmd_data  <= rx_data;
      end else if (cmd_ready) begin
        cmd_valid <= 1'b0;
      end
    end
  end

  // R2: downward sweep steps one slower per mismatch
  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_DOWN && rx_done && !match && div != D_SLOW) |=> div == $past(div) + DW'(1));

  // R4: upward sweep steps one faster per mismatch
  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_UP && rx_done && !match && div != D_FAST) |=> div == $past(div) - DW'(1));

  // R3: a match in the downward sweep moves to the slowest setting
  a_r3_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_DOWN && rx_done && match) |=> (st == C_UP && div == D_SLOW));

  // R6: wrap at the end stop of the downward sweep
  a_r6_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_DOWN && rx_done && !match && div == D_SLOW) |=> div == D_FAST);

  // R8: once locked the slave never leaves the run state
  a_r8_run_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_RUN) |=> (st == C_RUN && $stable(div)));

  // R9: a pending command holds until accepted
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

  // R10: nothing is presented before lock
  a_r10_no_cmd_before_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (st != C_RUN) |-> !cmd_valid);

endmodule

// File: rtl/autobaud_uart_slave.sv
module autobaud_uart_slave #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int BAUD_MAX  = 520_000,
  parameter int BAUD_MIN  = 58_000,
  parameter int SYNC_STG  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       serial_in,
  output logic       serial_out,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [7:0] cmd_data
);

  localparam int DIV_FAST = CLK_HZ / BAUD_MAX;
  localparam int DIV_SLOW = CLK_HZ / BAUD_MIN;
  localparam int DW       = $clog2(DIV_SLOW + 1);

  logic          line_s;
  logic          rx_done;
  logic          rx_ok;
  logic [7:0]    rx_data;
  logic          tx_go;
  logic          tx_busy;
  logic [7:0]    tx_byte;
  logic [DW-1:0] div;

  abr_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (serial_in),
    .dout (line_s)
  );

  abr_rx #(.DW(DW)) u_rx (
    .clk  (clk),
    .rst_n(rst_n),
    .line (line_s),
    .div  (div),
    .done (rx_done),
    .ok   (rx_ok),
    .data (rx_data)
  );

  abr_ctrl #(.DW(DW), .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_done  (rx_done),
    .rx_ok    (rx_ok),
    .rx_data  (rx_data),
    .tx_busy  (tx_busy),
    .tx_go    (tx_go),
    .tx_byte  (tx_byte),
    .div      (div),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_data (cmd_data)
  );

  abr_tx #(.DW(DW)) u_tx (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (tx_go),
    .din  (tx_byte),
    .div  (div),
    .line (serial_out),
    .busy (tx_busy)
  );

endmodule

// File: tb/test_autobaud_uart_slave.sv
`timescale 1ns/1ps
module test_autobaud_uart_slave;

  localparam int DF = 8;
  localparam int DS = 20;

  typedef struct packed {
    logic [7:0] b;
    logic       stopv;
    logic       echo;
  } vec_t;

  localparam vec_t TBL [7] = '{
    '{8'h3C, 1'b1, 1'b1},
    '{8'hAA, 1'b1, 1'b1},
    '{8'h00, 1'b1, 1'b1},
    '{8'h77, 1'b0, 1'b0},
    '{8'hFF, 1'b1, 1'b1},
    '{8'hA5, 1'b1, 1'b1},
    '{8'h5A, 1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       serial_out;
  logic       cmd_valid;
  logic       cmd_ready = 1'b0;
  logic [7:0] cmd_data;

  int  n_total = 0;
  int  n_pass  = 0;
  int  cyc = 0;
  int  fall_at = 0;
  int  low_len = 0;
  logic prev_tx = 1'b1;
  logic calib = 1'b0;
  logic search = 1'b0;
  logic saw_cmd = 1'b0;
  logic saw_tx = 1'b0;

  always #4 clk = ~clk;

  autobaud_uart_slave #(
    .CLK_HZ  (125_000_000),
    .BAUD_MAX(15_625_000),
    .BAUD_MIN(6_250_000)
  ) i_autobaud_uart_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .serial_in (rx),
    .serial_out(serial_out),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_data  (cmd_data)
  );

  always @(negedge clk) begin
    cyc++;
    if (prev_tx && !serial_out) fall_at = cyc;
    if (!prev_tx && serial_out) low_len = cyc - fall_at;
    prev_tx = serial_out;
    if (calib && cmd_valid) saw_cmd = 1'b1;
    if (search && !serial_out) saw_tx = 1'b1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_total++;
    if (act == exp) n_pass++;
    else $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  task automatic send_byte(input logic [7:0] b, input int d, input logic stopv);
    rx = 1'b0;
    tick(d);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      tick(d);
    end
    rx = stopv;
    tick(d);
    rx = 1'b1;
    tick(3 * d);
  endtask

  task automatic recv_byte(input int d, output logic got, output logic [7:0] b);
    int w;
    got = 1'b0;
    b = '0;
    w = 0;
    while (serial_out === 1'b1 && w < 60 * DS) begin
      tick(1);
      w++;
    end
    if (serial_out === 1'b0) begin
      got = 1'b1;
      tick(d / 2);
      for (int i = 0; i < 8; i++) begin
        tick(d);
        b[i] = serial_out;
      end
      tick(d);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rx = 1'b1;
    tick(4);
    rst_n = 1'b1;
    tick(2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    logic       got;
    logic [7:0] b;

    // ---------- run 1: both sweeps wrap ----------
    do_reset();
    chk("R1 serial_out idle", serial_out, 1);
    chk("R1 cmd_valid low", cmd_valid, 0);
    calib = 1'b1;
    search = 1'b1;
    for (int d = DF; d <= DS; d++) send_byte(8'h33, d, 1'b1);
    send_byte(8'hAA, DF, 1'b1);
    for (int d = DS; d >= DF; d--) send_byte(8'h33, d, 1'b1);
    search = 1'b0;
    fork
      send_byte(8'hAA, DS, 1'b1);
      begin
        recv_byte(14, got, b);
        chk("R6 first lock byte", b, 8'h55);
        recv_byte(14, got, b);
        chk("R6 second lock byte", b, 8'h55);
      end
    join
    chk("R6 centred period after wraps", low_len, 14);
    chk("R10 no tx during wrapping search", saw_tx, 0);

    // ---------- run 2: main calibration ----------
    do_reset();
    saw_tx = 1'b0;
    saw_cmd = 1'b0;
    chk("R1 idle after second reset", serial_out, 1);
    search = 1'b1;
    send_byte(8'h33, 8, 1'b1);
    send_byte(8'h5A, 9, 1'b1);
    send_byte(8'hAA, 10, 1'b0);   // R2: bad stop counts as mismatch
    send_byte(8'hAA, 11, 1'b1);   // R3: upper limit 11
    send_byte(8'h00, DS, 1'b1);   // R4
    send_byte(8'h55, DS - 1, 1'b1);
    search = 1'b0;
    fork
      send_byte(8'hAA, DS - 2, 1'b1);  // R4: lower limit 18
      begin
        recv_byte(15, got, b);
        chk("R5 lock byte one", b, 8'h55);
        recv_byte(15, got, b);
        chk("R5 lock byte two", b, 8'h55);
      end
    join
    chk("R5 bit period (11+18+1)/2", low_len, 15);
    chk("R3 R2 R4 limits give centre 15 (tx seen)", got, 1);
    chk("R10 no cmd before lock", saw_cmd, 0);
    chk("R10 no tx during search", saw_tx, 0);
    calib = 1'b0;

    // ---------- run-state vectors ----------
    for (int k = 0; k < 7; k++) begin
      fork
        send_byte(TBL[k].b, 15, TBL[k].stopv);
        recv_byte(15, got, b);
      join
      chk($sformatf("R7 R11 echo present v%0d", k), got, TBL[k].echo);
      if (TBL[k].echo) begin
        chk($sformatf("R7 R8 echo value v%0d", k), b, TBL[k].b);
        chk($sformatf("R8 cmd_valid v%0d", k), cmd_valid, 1);
        chk($sformatf("R8 cmd_data v%0d", k), cmd_data, TBL[k].b);
        cmd_ready = 1'b1;
        tick(1);
        cmd_ready = 1'b0;
        tick(1);
        chk($sformatf("R9 accepted v%0d", k), cmd_valid, 0);
      end else begin
        chk($sformatf("R11 no cmd v%0d", k), cmd_valid, 0);
      end
    end

    // ---------- back-pressure ----------
    fork
      begin
        send_byte(8'h11, 15, 1'b1);
        send_byte(8'h22, 15, 1'b1);
      end
      begin
        recv_byte(15, got, b);
        chk("R9 echo first", b, 8'h11);
        recv_byte(15, got, b);
        chk("R9 echo second while pending", b, 8'h22);
      end
    join
    chk("R9 still valid", cmd_valid, 1);
    chk("R9 held data", cmd_data, 8'h11);
    cmd_ready = 1'b1;
    tick(1);
    cmd_ready = 1'b0;
    tick(1);
    chk("R9 second byte dropped", cmd_valid, 0);

    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

endmodule